// File: doc/BRIEF.md
# Sleep Entry and Watchdog Status Controller

This block sits beside an instruction decoder and handles the power-down instruction. When a valid instruction word equal to the sleep opcode arrives, the block raises a clock-stop request on the next clock edge. In the same cycle it sends a one-cycle clear pulse to the watchdog counter and another to the watchdog postscaler. It also sets the time-out flag and clears the power-down flag.

While asleep, the block ignores further sleep decodes but still listens to the watchdog time-out and an external wake event. A watchdog time-out ends sleep and clears the time-out flag. An external wake ends sleep and leaves both flags untouched. Software reading the two flags after waking can therefore tell the causes apart: power-down low with time-out low means a watchdog wake, and power-down low with time-out high means an external wake. The watchdog counter, the oscillator and any interrupt logic are outside the block and are seen only through their clear and time-out signals.

Top module: `slp_ctrl`

## Requirements
- R1: During and immediately after reset, `to_o`=1, `pd_o`=1, `sleep_o`=0, `wdt_clr_o`=0 and `wdt_post_clr_o`=0.
- R2: A cycle with `instr_vld_i`=1 and `instr_i`=16'h0003 while awake makes, on the next cycle, `sleep_o`=1, `to_o`=1 and `pd_o`=0.
- R3: `wdt_clr_o` and `wdt_post_clr_o` are both 1 for exactly the one cycle that follows an accepted sleep decode, and are 0 at all other times.
- R4: A cycle with `wdt_timeout_i`=1 while asleep makes, on the next cycle, `sleep_o`=0, `to_o`=0 and `pd_o`=0.
- R5: A cycle with `wake_i`=1 and `wdt_timeout_i`=0 while asleep makes, on the next cycle, `sleep_o`=0, with `to_o` and `pd_o` unchanged.
- R6: When `wdt_timeout_i` and `wake_i` are both 1 in the same cycle while asleep, the wake is reported as a watchdog wake (`to_o`=0).
- R7: A sleep decode while asleep has no effect: no clear pulse, `sleep_o` stays 1, and the flags are unchanged.
- R8: An instruction word other than 16'h0003, or any word with `instr_vld_i`=0, changes no output.
- R9: A cycle with `wdt_timeout_i`=1 while awake, and no sleep decode, makes `to_o`=0 on the next cycle, with `pd_o` unchanged and `sleep_o` still 0.
- R10: While awake, a sleep decode in the same cycle as a watchdog time-out takes priority: sleep is entered with `to_o`=1.
- R11: Whenever `sleep_o` is 1, `pd_o` is 0.
- R12: `wake_i` while awake changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low power-on reset |
| instr_i | input | 16 | Instruction word under decode |
| instr_vld_i | input | 1 | Instruction word is valid this cycle |
| wdt_timeout_i | input | 1 | Watchdog time-out event |
| wake_i | input | 1 | External wake event |
| to_o | output | 1 | Time-out status flag |
| pd_o | output | 1 | Power-down status flag |
| wdt_clr_o | output | 1 | Clear pulse to the watchdog counter |
| wdt_post_clr_o | output | 1 | Clear pulse to the watchdog postscaler |
| sleep_o | output | 1 | Sleep / clock-stop request |

## Verification
The assertions check the one-cycle relations on every cycle. These are the entry effects of a decode and the wake effects of each event, including the priority between simultaneous events. They also check that clear pulses appear only together with a rising sleep request and that the power-down flag is low throughout sleep. Only the bench scenarios can show longer sequences. One is several sleep and wake rounds in a row, where the flags that survive an external wake reflect an earlier entry. Another is the reset values. A third is that near-miss opcodes and unqualified words leave every output untouched over many cycles.

// File: rtl/slp_pkg.sv
package slp_pkg;

    // Events derived from the inputs and the current sleep state.
    typedef struct packed {
        logic enter;      // accepted sleep decode while awake
        logic wdt_wake;   // watchdog time-out while asleep
        logic ext_wake;   // external wake while asleep, no time-out
        logic awake_tmo;  // watchdog time-out while awake, no decode
    } slp_evt_t;

    typedef struct packed {
        logic to;
        logic pd;
    } slp_stat_t;

    typedef struct packed {
        logic asleep;
        logic wdt_clr;
        logic post_clr;
    } slp_pwr_t;

    localparam slp_stat_t STAT_RESET = '{to: 1'b1, pd: 1'b1};
    localparam slp_pwr_t  PWR_RESET  = '{asleep: 1'b0, wdt_clr: 1'b0, post_clr: 1'b0};

endpackage

// File: rtl/slp_decode.sv
module slp_decode #(
    parameter int                   INSTR_W      = 16,
    parameter logic [INSTR_W-1:0]   SLEEP_OPCODE = 16'h0003
) (
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               vld_i,
    output logic               hit_o
);

    always_comb begin
        hit_o = vld_i && (instr_i == SLEEP_OPCODE);
    end

endmodule

// File: rtl/slp_power.sv
module slp_power
    import slp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hit_i,
    input  logic     tmo_i,
    input  logic     wake_i,
    output slp_evt_t evt_o,
    output logic     asleep_o,
    output logic     wdt_clr_o,
    output logic     post_clr_o
);

    slp_pwr_t pwr_d, pwr_q;
    slp_evt_t evt;

    always_comb begin
        evt.enter     = hit_i && !pwr_q.asleep;
        evt.wdt_wake  = pwr_q.asleep && tmo_i;
        evt.ext_wake  = pwr_q.asleep && wake_i && !tmo_i;
        evt.awake_tmo = !pwr_q.asleep && tmo_i && !hit_i;

        pwr_d          = pwr_q;
        pwr_d.wdt_clr  = evt.enter;
        pwr_d.post_clr = evt.enter;
        if (evt.enter) begin
            pwr_d.asleep = 1'b1;
        end else if (evt.wdt_wake || evt.ext_wake) begin
            pwr_d.asleep = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q <= PWR_RESET;
        end else begin
            pwr_q <= pwr_d;
        end
    end

    assign evt_o      = evt;
    assign asleep_o   = pwr_q.asleep;
    assign wdt_clr_o  = pwr_q.wdt_clr;
    assign post_clr_o = pwr_q.post_clr;

endmodule

// File: rtl/slp_status.sv
module slp_status
    import slp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  slp_evt_t evt_i,
    output logic     to_o,
    output logic     pd_o
);

    slp_stat_t stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (evt_i.enter) begin
            stat_d.to = 1'b1;
            stat_d.pd = 1'b0;
        end else if (evt_i.wdt_wake || evt_i.awake_tmo) begin
            stat_d.to = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= STAT_RESET;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign to_o = stat_q.to;
    assign pd_o = stat_q.pd;

endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
    import slp_pkg::*;
#(
    parameter int                   INSTR_W      = 16,
    parameter logic [INSTR_W-1:0]   SLEEP_OPCODE = 16'h0003
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               instr_vld_i,
    input  logic               wdt_timeout_i,
    input  logic               wake_i,
    output logic               to_o,
    output logic               pd_o,
    output logic               wdt_clr_o,
    output logic               wdt_post_clr_o,
    output logic               sleep_o
);

    logic     hit;
    slp_evt_t evt;

    slp_decode #(
        .INSTR_W      (INSTR_W),
        .SLEEP_OPCODE (SLEEP_OPCODE)
    ) u_decode (
        .instr_i (instr_i),
        .vld_i   (instr_vld_i),
        .hit_o   (hit)
    );

    slp_power u_power (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hit),
        .tmo_i      (wdt_timeout_i),
        .wake_i     (wake_i),
        .evt_o      (evt),
        .asleep_o   (sleep_o),
        .wdt_clr_o  (wdt_clr_o),
        .post_clr_o (wdt_post_clr_o)
    );

    slp_status u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt),
        .to_o  (to_o),
        .pd_o  (pd_o)
    );

endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk #(
    parameter int                   INSTR_W      = 16,
    parameter logic [INSTR_W-1:0]   SLEEP_OPCODE = 16'h0003
) (
    input logic               clk,
    input logic               rst_n,
    input logic [INSTR_W-1:0] instr_i,
    input logic               instr_vld_i,
    input logic               wdt_timeout_i,
    input logic               wake_i,
    input logic               to_o,
    input logic               pd_o,
    input logic               wdt_clr_o,
    input logic               wdt_post_clr_o,
    input logic               sleep_o
);

    logic dec;
    assign dec = instr_vld_i && (instr_i == SLEEP_OPCODE);

    assert_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !sleep_o) |=> (sleep_o && to_o && !pd_o));

    assert_clr_on_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !sleep_o) |=> (wdt_clr_o && wdt_post_clr_o));

    assert_clr_only_with_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_clr_o || wdt_post_clr_o) |-> $rose(sleep_o));

    assert_wdt_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && wdt_timeout_i) |=> (!sleep_o && !to_o && !pd_o));

    assert_ext_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && wake_i && !wdt_timeout_i) |=> (!sleep_o && $stable(to_o) && $stable(pd_o)));

    assert_both_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && wake_i && wdt_timeout_i) |=> !to_o);

    assert_ignore_asleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && dec && !wdt_timeout_i && !wake_i) |=>
            (sleep_o && !wdt_clr_o && $stable(to_o) && $stable(pd_o)));

    assert_awake_tmo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_o && wdt_timeout_i && !dec) |=> (!to_o && $stable(pd_o) && !sleep_o));

    assert_decode_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_o && wdt_timeout_i && dec) |=> (sleep_o && to_o));

    assert_sleep_pd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |-> !pd_o);

endmodule

bind slp_ctrl slp_ctrl_chk #(
    .INSTR_W      (INSTR_W),
    .SLEEP_OPCODE (SLEEP_OPCODE)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .instr_i        (instr_i),
    .instr_vld_i    (instr_vld_i),
    .wdt_timeout_i  (wdt_timeout_i),
    .wake_i         (wake_i),
    .to_o           (to_o),
    .pd_o           (pd_o),
    .wdt_clr_o      (wdt_clr_o),
    .wdt_post_clr_o (wdt_post_clr_o),
    .sleep_o        (sleep_o)
);

// File: tb/sim_slp_ctrl.sv
`timescale 1ns/1ps
module sim_slp_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic        vld = 1'b0;
    logic        tmo = 1'b0;
    logic        wake = 1'b0;
    logic        to_o, pd_o, wdt_clr, post_clr, slp;

    always #5 clk = ~clk;

    slp_ctrl u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .instr_i        (instr),
        .instr_vld_i    (vld),
        .wdt_timeout_i  (tmo),
        .wake_i         (wake),
        .to_o           (to_o),
        .pd_o           (pd_o),
        .wdt_clr_o      (wdt_clr),
        .wdt_post_clr_o (post_clr),
        .sleep_o        (slp)
    );

    typedef struct {
        logic  to;
        logic  pd;
        logic  slp;
        logic  clr;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;

    // Bench model of the flags, built from the requirements.
    logic m_to = 1'b1, m_pd = 1'b1, m_slp = 1'b0;

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {to,pd,sleep,clr} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic step(input logic [15:0] w, input logic v, input logic t,
                        input logic k, input string tag);
        exp_t e;
        logic hit;
        logic clr;
        @(negedge clk);
        instr = w; vld = v; tmo = t; wake = k;
        hit = v && (w == 16'h0003);
        clr = 1'b0;
        if (!m_slp) begin
            if (hit) begin
                m_to = 1'b1; m_pd = 1'b0; m_slp = 1'b1; clr = 1'b1;
            end else if (t) begin
                m_to = 1'b0;
            end
        end else begin
            if (t) begin
                m_slp = 1'b0; m_to = 1'b0;
            end else if (k) begin
                m_slp = 1'b0;
            end
        end
        @(posedge clk);
        #1;
        e.to = m_to; e.pd = m_pd; e.slp = m_slp; e.clr = clr; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare at the falling edge after the result was registered.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, {to_o, pd_o, slp, wdt_clr}, {e.to, e.pd, e.slp, e.clr});
                // R3: the postscaler clear must match the counter clear expectation
                check({e.tag, " R3 postscaler"}, {3'b000, post_clr}, {3'b000, e.clr});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", {to_o, pd_o, slp, wdt_clr}, 4'b1100);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {to_o, pd_o, slp, post_clr}, 4'b1100);

        // R8: near-miss opcodes and unqualified words
        step(16'h0004, 1'b1, 1'b0, 1'b0, "R8 opcode 0004");
        step(16'h0002, 1'b1, 1'b0, 1'b0, "R8 opcode 0002");
        step(16'h8003, 1'b1, 1'b0, 1'b0, "R8 opcode 8003");
        step(16'h0003, 1'b0, 1'b0, 1'b0, "R8 valid low");
        // R12: wake while awake
        step(16'h0000, 1'b0, 1'b0, 1'b1, "R12 wake while awake");

        // R2/R3: entry
        step(16'h0003, 1'b1, 1'b0, 1'b0, "R2 R3 sleep entry");
        step(16'h0000, 1'b0, 1'b0, 1'b0, "R3 pulse ends, R11 asleep");
        // R7: decodes while asleep
        step(16'h0003, 1'b1, 1'b0, 1'b0, "R7 decode asleep");
        step(16'h0003, 1'b1, 1'b0, 1'b0, "R7 decode asleep again");
        // R4: watchdog wake
        step(16'h0000, 1'b0, 1'b1, 1'b0, "R4 watchdog wake");
        step(16'h0000, 1'b0, 1'b0, 1'b0, "R4 awake idle");

        // R5: external wake keeps flags
        step(16'h0003, 1'b1, 1'b0, 1'b0, "R2 re-entry");
        step(16'h0000, 1'b0, 1'b0, 1'b1, "R5 external wake");
        step(16'h0000, 1'b0, 1'b0, 1'b0, "R5 awake idle");

        // R6: both wake causes together
        step(16'h0003, 1'b1, 1'b0, 1'b0, "R2 entry before both");
        step(16'h0000, 1'b0, 1'b1, 1'b1, "R6 both wake causes");

        // R9: time-out while awake
        step(16'h0003, 1'b1, 1'b0, 1'b0, "R2 entry");
        step(16'h0000, 1'b0, 1'b0, 1'b1, "R5 wake");
        step(16'h0000, 1'b0, 1'b1, 1'b0, "R9 awake timeout");

        // R10: decode and time-out together while awake
        step(16'h0003, 1'b1, 1'b1, 1'b0, "R10 decode wins");
        step(16'h0000, 1'b0, 1'b0, 1'b0, "R11 asleep idle");
        step(16'h0000, 1'b0, 1'b1, 1'b0, "R4 wake after R10");

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule